// File: doc/BRIEF.md
# Doubleword Rotate-Then-Clear Execution Unit

This unit executes one 64-bit integer operation of a PowerPC-style core: rotate a source doubleword left by an immediate amount, then zero the bits on both sides of a window. It receives a 32-bit instruction word, the value already read from the source register, and the current summary-overflow bit. It decodes the operation, its register indices and its two split immediates, and produces a registered result one clock later. With the result come a register write enable, the destination index, and, for the recording form, a 4-bit condition field.

The shift count and the window start are each 6 bits wide, and both are scattered across the instruction word. The window keeps the rotated bits from the start position through the position the shift count implies. When the start lies past that position, the window is empty and the result is zero. With a start of zero, the operation is a plain logical left shift. A word whose opcode fields do not name this operation is flagged, and nothing is written back.

Top module: `rotclr_unit`

## Requirements
- R1: Bits [31:26] of `instr_i` must equal 30 and bits [4:2] must equal 2 for the word to be accepted. For an accepted word, `rs_idx_o` = `instr_i[25:21]`, `ra_idx_o` = `instr_i[20:16]` and `gpr_we_o` = 1.
- R2: The shift count is SH = {instr_i[1], instr_i[15:11]} and the window start is MB = {instr_i[5], instr_i[10:6]} (instr_i[5] is the MSB of MB).
- R3: `result_o` equals the source rotated left by SH, with only the bits at LSB positions SH through 63−MB (inclusive) kept. All other bits are zero.
- R4: When MB + SH > 63, `result_o` is all zeros.
- R5: When MB = 0, `result_o` equals the source logically shifted left by SH.
- R6: When instr_i[0] = 1 on an accepted word, `cr_we_o` = 1 and `cr0_o` = {LT, GT, EQ, SO} (bits 3..0). LT, GT and EQ come from a 64-bit signed compare of the result with zero, and SO copies `so_i`. When instr_i[0] = 0, `cr_we_o` = 0.
- R7: `xer_we_o`, `ca_o` and `ov_o` are always 0.
- R8: A valid word that fails the R1 opcode test gives `illegal_o` = 1, with `gpr_we_o` = 0 and `cr_we_o` = 0.
- R9: All outputs are registered and change on the clock edge after the inputs are sampled. While `valid_i` = 0, `vld_o`, `gpr_we_o`, `cr_we_o` and `illegal_o` are 0. A synchronous reset sets every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word and operands are present |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 64 | Source register value |
| so_i | input | 1 | Current summary-overflow bit |
| vld_o | output | 1 | Registered copy of valid_i |
| rs_idx_o | output | 5 | Decoded source register index |
| ra_idx_o | output | 5 | Decoded destination register index |
| result_o | output | 64 | Rotated and cleared result |
| gpr_we_o | output | 1 | Register write enable |
| cr_we_o | output | 1 | Condition field 0 write enable |
| cr0_o | output | 4 | {LT, GT, EQ, SO} |
| xer_we_o | output | 1 | Status register write enable, always 0 |
| ca_o | output | 1 | Carry output, always 0 |
| ov_o | output | 1 | Overflow output, always 0 |
| illegal_o | output | 1 | Word does not name this operation |

## Verification
The bench builds the unit with its default 64-bit data width. At that width the 6-bit shift and start fields reach every value from 0 to 63. This brings the zero shift, the full 63-bit shift, a start of 63, and start-plus-shift sums well past 63 within reach, which makes the empty window reachable. The bench also uses words whose opcode or extended opcode is wrong, plus results that are negative, positive and zero, so that each of the three compare outcomes is produced.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam logic [5:0] OPCD_ROTCLR = 6'd30;
  localparam logic [2:0] XO_ROTCLR   = 3'd2;

  typedef struct packed {
    logic [4:0] rs;
    logic [4:0] ra;
    logic [5:0] sh;
    logic [5:0] mb;
    logic       rec;
    logic       legal;
  } rc_fields_t;
endpackage

// File: rtl/rc_decode.sv
module rc_decode
  import rc_pkg::*;
(
  input  logic [31:0] instr_i,
  output rc_fields_t  fld_o
);
  always_comb begin
    fld_o.legal = (instr_i[31:26] == OPCD_ROTCLR) && (instr_i[4:2] == XO_ROTCLR);
    fld_o.rs    = instr_i[25:21];
    fld_o.ra    = instr_i[20:16];
    fld_o.sh    = {instr_i[1], instr_i[15:11]};
    fld_o.mb    = {instr_i[5], instr_i[10:6]};
    fld_o.rec   = instr_i[0];
  end
endmodule

// File: rtl/rc_rotator.sv
module rc_rotator #(
  parameter int W = 64,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din_i,
  input  logic [SHW-1:0] amt_i,
  output logic [W-1:0]   dout_o
);
  logic [W-1:0] stage [0:SHW];
  assign stage[0] = din_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int A = 1 << k;
    assign stage[k+1] = amt_i[k] ? {stage[k][W-1-A:0], stage[k][W-1:W-A]} : stage[k];
  end

  assign dout_o = stage[SHW];
endmodule

// File: rtl/rc_maskgen.sv
module rc_maskgen #(
  parameter int W = 64,
  localparam int SHW = $clog2(W)
) (
  input  logic [SHW-1:0] sh_i,
  input  logic [SHW-1:0] mb_i,
  output logic [W-1:0]   mask_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [SHW-1:0] LO_IDX = SHW'(i);
    localparam logic [SHW-1:0] HI_IDX = SHW'(W - 1 - i);
    assign mask_o[i] = (LO_IDX >= sh_i) && (HI_IDX >= mb_i);
  end
endmodule

// File: rtl/rc_crgen.sv
module rc_crgen #(
  parameter int W = 64
) (
  input  logic [W-1:0] res_i,
  input  logic         so_i,
  output logic [3:0]   cr_o
);
  logic neg, zero;
  assign neg  = res_i[W-1];
  assign zero = (res_i == '0);
  assign cr_o = {neg, !neg && !zero, zero, so_i};
endmodule

// File: rtl/rotclr_unit.sv
module rotclr_unit
  import rc_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int SHW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic              so_i,
  output logic              vld_o,
  output logic [4:0]        rs_idx_o,
  output logic [4:0]        ra_idx_o,
  output logic [DATA_W-1:0] result_o,
  output logic              gpr_we_o,
  output logic              cr_we_o,
  output logic [3:0]        cr0_o,
  output logic              xer_we_o,
  output logic              ca_o,
  output logic              ov_o,
  output logic              illegal_o
);
  rc_fields_t        fld;
  logic [DATA_W-1:0] rot, mask, res_c;
  logic [3:0]        cr_c;

  rc_decode u_dec (.instr_i(instr_i), .fld_o(fld));

  rc_rotator #(.W(DATA_W)) u_rot (
    .din_i(rs_val_i), .amt_i(fld.sh[SHW-1:0]), .dout_o(rot)
  );

  rc_maskgen #(.W(DATA_W)) u_mask (
    .sh_i(fld.sh[SHW-1:0]), .mb_i(fld.mb[SHW-1:0]), .mask_o(mask)
  );

  assign res_c = rot & mask;

  rc_crgen #(.W(DATA_W)) u_cr (.res_i(res_c), .so_i(so_i), .cr_o(cr_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o     <= 1'b0;
      rs_idx_o  <= '0;
      ra_idx_o  <= '0;
      result_o  <= '0;
      gpr_we_o  <= 1'b0;
      cr_we_o   <= 1'b0;
      cr0_o     <= '0;
      illegal_o <= 1'b0;
    end else begin
      vld_o     <= valid_i;
      rs_idx_o  <= fld.rs;
      ra_idx_o  <= fld.ra;
      result_o  <= res_c;
      gpr_we_o  <= valid_i && fld.legal;
      cr_we_o   <= valid_i && fld.legal && fld.rec;
      cr0_o     <= cr_c;
      illegal_o <= valid_i && !fld.legal;
    end
  end

  assign xer_we_o = 1'b0;
  assign ca_o     = 1'b0;
  assign ov_o     = 1'b0;
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_i,
  input logic [31:0]  instr_i,
  input logic [W-1:0] rs_val_i,
  input logic         vld_o,
  input logic [4:0]   rs_idx_o,
  input logic [4:0]   ra_idx_o,
  input logic [W-1:0] result_o,
  input logic         gpr_we_o,
  input logic         cr_we_o,
  input logic [3:0]   cr0_o,
  input logic         illegal_o
);
  logic       ok;
  logic [5:0] sh, mb;
  logic [6:0] span;
  assign ok   = (instr_i[31:26] == 6'd30) && (instr_i[4:2] == 3'd2);
  assign sh   = {instr_i[1], instr_i[15:11]};
  assign mb   = {instr_i[5], instr_i[10:6]};
  assign span = {1'b0, sh} + {1'b0, mb};

  p_idx_r1: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (ra_idx_o == $past(instr_i[20:16])) && (rs_idx_o == $past(instr_i[25:21])));

  p_empty_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ok && span > 7'd63) |=> (result_o == '0));

  p_shift_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ok && mb == 6'd0) |=> (result_o == ($past(rs_val_i) << $past(sh))));

  p_cr_sign_r6: assert property (@(posedge clk) disable iff (rst)
    cr_we_o |-> (cr0_o[3] == result_o[W-1]) && (cr0_o[1] == (result_o == '0))
                && ($countones(cr0_o[3:1]) == 1));

  p_cr_norec_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !instr_i[0]) |=> !cr_we_o);

  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!gpr_we_o && !cr_we_o));

  p_bubble_r9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!vld_o && !gpr_we_o && !illegal_o && !cr_we_o));
endmodule

bind rotclr_unit rc_checker #(.W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i), .rs_val_i(rs_val_i),
  .vld_o(vld_o), .rs_idx_o(rs_idx_o), .ra_idx_o(ra_idx_o), .result_o(result_o),
  .gpr_we_o(gpr_we_o), .cr_we_o(cr_we_o), .cr0_o(cr0_o), .illegal_o(illegal_o)
);

// File: tb/rotclr_unit_tb_top.sv
`timescale 1ns/1ps
module rotclr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] rs_val_i = '0;
  logic        so_i = 1'b0;
  logic        vld_o, gpr_we_o, cr_we_o, xer_we_o, ca_o, ov_o, illegal_o;
  logic [4:0]  rs_idx_o, ra_idx_o;
  logic [63:0] result_o;
  logic [3:0]  cr0_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rotclr_unit dut_i (.*);

  // expected values for the word applied in the current cycle
  logic        e_vld, e_gwe, e_cwe, e_ill;
  logic [4:0]  e_rs, e_ra;
  logic [63:0] e_res;
  logic [3:0]  e_cr;

  function automatic logic [31:0] mk(input int opc, input int xo, input int rs,
                                     input int ra, input int sh, input int mb, input int rc);
    logic [31:0] w = '0;
    w[31:26] = 6'(opc); w[25:21] = 5'(rs); w[20:16] = 5'(ra);
    w[15:11] = 5'(sh % 32); w[1] = (sh >= 32);
    w[10:6] = 5'(mb % 32); w[5] = (mb >= 32);
    w[4:2] = 3'(xo); w[0] = rc[0];
    return w;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model from the requirements
  task automatic model(input logic v, input int opc, input int xo, input int rs, input int ra,
                       input int sh, input int mb, input int rc, input logic [63:0] src,
                       input logic so);
    logic [63:0] r;
    bit legal = (opc == 30) && (xo == 2);
    for (int i = 0; i < 64; i++) begin
      int from = (i - sh + 64) % 64;
      r[i] = (i >= sh && i <= 63 - mb) ? src[from] : 1'b0;
    end
    e_vld = v; e_rs = 5'(rs); e_ra = 5'(ra); e_res = r;
    e_gwe = v && legal; e_cwe = v && legal && (rc != 0); e_ill = v && !legal;
    if ($signed(r) < 0)      e_cr = {3'b100, so};
    else if ($signed(r) > 0) e_cr = {3'b010, so};
    else                     e_cr = {3'b001, so};
  endtask

  task automatic apply(input logic v, input int opc, input int xo, input int rs, input int ra,
                       input int sh, input int mb, input int rc, input logic [63:0] src,
                       input logic so, input string tag);
    valid_i = v; instr_i = mk(opc, xo, rs, ra, sh, mb, rc); rs_val_i = src; so_i = so;
    model(v, opc, xo, rs, ra, sh, mb, rc, src, so);
    @(negedge clk);
    check({tag, " R9 vld"}, 64'(vld_o), 64'(e_vld));
    check({tag, " R1 gpr_we"}, 64'(gpr_we_o), 64'(e_gwe));
    check({tag, " R8 illegal"}, 64'(illegal_o), 64'(e_ill));
    check({tag, " R6 cr_we"}, 64'(cr_we_o), 64'(e_cwe));
    check({tag, " R7 xer"}, 64'({xer_we_o, ca_o, ov_o}), 64'(0));
    if (v) begin
      check({tag, " R1 idx"}, 64'({rs_idx_o, ra_idx_o}), 64'({e_rs, e_ra}));
      if (e_gwe) check({tag, " R3 result"}, result_o, e_res);
      if (e_cwe) check({tag, " R6 cr0"}, 64'(cr0_o), 64'(e_cr));
    end
  endtask

  logic [63:0] seed = 64'h0123_4567_89ab_cdef;
  function automatic logic [63:0] nxt(inout logic [63:0] s);
    s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
    return s;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset result", result_o, 64'd0);
    check("R9 reset flags", 64'({vld_o, gpr_we_o, cr_we_o, illegal_o, cr0_o}), 64'd0);
    rst = 1'b0;

    // R5: MB = 0, SH = 0 -> identity shift
    apply(1, 30, 2, 3, 4, 0, 0, 1, 64'h8000_0000_0000_0001, 1'b1, "R5 sh0");
    // R5: MB = 0 shift by 12
    apply(1, 30, 2, 5, 6, 12, 0, 1, 64'hdead_beef_1234_5678, 1'b0, "R5 sh12");
    // R2 high bit of SH: SH = 63
    apply(1, 30, 2, 7, 8, 63, 0, 1, 64'h0000_0000_0000_0003, 1'b0, "R2 sh63");
    // R2 high bit of MB: MB = 63, SH = 0 keeps only LSB
    apply(1, 30, 2, 9, 10, 0, 63, 1, 64'hffff_ffff_ffff_ffff, 1'b1, "R2 mb63");
    // R4 empty window
    apply(1, 30, 2, 11, 12, 40, 30, 1, 64'hffff_ffff_ffff_ffff, 1'b1, "R4 empty");
    apply(1, 30, 2, 11, 12, 1, 63, 0, 64'hffff_ffff_ffff_ffff, 1'b0, "R4 edge");
    // R3 exact boundary MB + SH = 63 keeps one bit
    apply(1, 30, 2, 1, 2, 33, 30, 1, 64'h0000_0000_0000_0001, 1'b0, "R3 onebit");
    // R6 positive result, record form off
    apply(1, 30, 2, 13, 14, 4, 8, 0, 64'h0f0f_0f0f_0f0f_0f0f, 1'b1, "R6 norec");
    // R8 wrong primary and wrong extended opcode
    apply(1, 31, 2, 15, 16, 4, 8, 1, 64'h1, 1'b0, "R8 opcd");
    apply(1, 30, 3, 17, 18, 4, 8, 1, 64'h1, 1'b0, "R8 xo");
    // R9 bubble
    apply(0, 30, 2, 19, 20, 4, 8, 1, 64'h1, 1'b0, "R9 bubble");

    // R3 sweep of mixed patterns
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a = nxt(seed);
      logic [63:0] b = nxt(seed);
      int sh = int'(a[13:8]);
      int mb = int'(a[21:16]);
      if (n % 7 == 0) mb = 0;
      apply(a[40] | a[41], 30, 2, int'(a[28:24]), int'(a[36:32]), sh, mb, int'(a[44]),
            b, a[50], "R3 sweep");
    end

    valid_i = 1'b0;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule